// File: doc/BRIEF.md
# Ternary Closure Selector

This block is a purely combinational selector that works on three-valued signals: every data and select line carries a stable 0, a stable 1, or an undetermined value M, each coded on two wires. It has 2^SEL_W data inputs and an SEL_W-digit select. When the select digits are all stable, it returns the addressed data item. When some select digits are M, it returns a stable value only if every way of resolving those digits to 0 or 1 addresses data items that all hold that same stable value. Otherwise it returns M. No ambiguity on the select can therefore turn into an unresolved output when the outcome is already fixed.

The block is built as a binary tree of two-input containing multiplexer cells. Select digit 0 drives the level nearest the data. Each cell carries a consensus term that forces a stable output whenever both of its data inputs agree, even if its select is M. A parameter can remove that term, which gives an ordinary AND-OR tree for comparison. If the data inputs are tied to the truth table of a Boolean function of SEL_W variables, the block evaluates the three-valued closure of that function at the select value.

Top module: `tern_closure_mux`

## Requirements
- R1: Each signal uses two wires: 00 means 0, 11 means 1, and 01 means M. The output only ever takes the values 00, 11 or 01.
- R2: Data item i sits at `data_i[2*i+1:2*i]` and select digit j sits at `sel_i[2*j+1:2*j]`. With every select digit stable, the output is the canonical value of the data item whose index is the binary number formed by the select digits, with digit 0 as the least significant bit.
- R3: If every data item is stable 1, the output is 1, and if every data item is stable 0, the output is 0, whatever the select digits hold.
- R4: For any mix of inputs, the output is stable b when every data item reachable by some resolution of the M select digits is stable b. Otherwise the output is M.
- R5: When select digit 0 is M and the two candidate items agree (both 1 or both 0), the output is that stable value. When they differ, the output is M.
- R6: An M on a data item that no resolution of the select can reach has no effect on the output. An M on a reachable data item makes the output M.
- R7: With data item i tied to f(i) for a Boolean f of SEL_W inputs, the output equals the three-valued closure of f at the select value.
- R8: With CONTAIN = 0 the cells drop the consensus term. Both candidates at 1 with an M select then give M, while a fully stable select still gives the addressed item.
- R9: The code 10 on any data or select input is treated exactly like 01 (M).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 2*2^SEL_W | Data items, two wires each, item 0 in the lowest pair |
| sel_i | input | 2*SEL_W | Select digits, two wires each, digit 0 in the lowest pair |
| y_o | output | 2 | Selected value in canonical two-wire code |

## Verification
Every result of this block is combinational, so it is due in the same cycle as the stimulus that produces it. The bench changes the inputs just after a rising edge and samples the output at the following falling edge, half a period later, so it never reads values while they are still settling. The containing instance and the plain comparison instance receive the same inputs and are sampled at the same point. Expected values come from enumerating every stable resolution of the select in the bench.

// File: rtl/tern_pkg.sv
// Package: shared two-wire ternary type and gate functions.
// Assumes canonical operands: bit 1 = "surely 1", bit 0 = "possibly 1",
// so 00 = 0, 11 = 1, 01 = M (bit 1 never set without bit 0).
package tern_pkg;
    typedef logic [1:0] tern_t;

    // Ternary AND: both rails combine monotonically.
    function automatic tern_t tern_and(tern_t a, tern_t b);
        return {a[1] & b[1], a[0] & b[0]};
    endfunction

    // Ternary OR.
    function automatic tern_t tern_or(tern_t a, tern_t b);
        return {a[1] | b[1], a[0] | b[0]};
    endfunction

    // Ternary NOT: swaps and inverts the rails, M stays M.
    function automatic tern_t tern_not(tern_t a);
        return {~a[0], ~a[1]};
    endfunction
endpackage

// File: rtl/tern_normalize.sv
// Module: maps N two-wire inputs onto the canonical code.
// 10 becomes 01 (M); 00, 11 and 01 pass unchanged.
module tern_normalize #(
    parameter int N = 8
) (
    input  logic [2*N-1:0] raw_i,
    output logic [2*N-1:0] canon_o
);
    for (genvar i = 0; i < N; i++) begin : g_item
        // Surely-1 rail needs both wires high, possibly-1 rail needs either.
        assign canon_o[2*i+:2] = {raw_i[2*i+1] & raw_i[2*i], raw_i[2*i+1] | raw_i[2*i]};
    end
endmodule

// File: rtl/tern_leaf_mux.sv
// Module: two-input ternary multiplexer cell.
// CONTAIN = 1 adds the consensus term a&b so agreeing inputs give a stable
// output under an M select; CONTAIN = 0 is the plain AND-OR form.
// Assumes canonical inputs.
module tern_leaf_mux
    import tern_pkg::*;
#(
    parameter bit CONTAIN = 1'b1
) (
    input  tern_t a_i,
    input  tern_t b_i,
    input  tern_t s_i,
    output tern_t y_o
);
    tern_t pick_a;
    tern_t pick_b;

    // Steering terms shared by both variants.
    assign pick_a = tern_and(a_i, tern_not(s_i));
    assign pick_b = tern_and(b_i, s_i);

    if (CONTAIN) begin : g_contain
        // Third OR input holds the output when both data agree.
        assign y_o = tern_or(tern_or(pick_a, pick_b), tern_and(a_i, b_i));
    end else begin : g_plain
        // Plain two-term multiplexer.
        assign y_o = tern_or(pick_a, pick_b);
    end
endmodule

// File: rtl/tern_mux_level.sv
// Module: one tree level, ITEMS inputs reduced to ITEMS/2 by leaf cells
// sharing one select digit. Assumes ITEMS even and canonical inputs.
module tern_mux_level
    import tern_pkg::*;
#(
    parameter int ITEMS   = 8,
    parameter bit CONTAIN = 1'b1
) (
    input  logic [2*ITEMS-1:0] d_i,
    input  tern_t              s_i,
    output logic [ITEMS-1:0]   y_o
);
    localparam int PAIRS = ITEMS / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // Even item goes to the 0 side, odd item to the 1 side.
        tern_leaf_mux #(.CONTAIN(CONTAIN)) i_leaf (
            .a_i (d_i[4*p+:2]),
            .b_i (d_i[4*p+2+:2]),
            .s_i (s_i),
            .y_o (y_o[2*p+:2])
        );
    end
endmodule

// File: rtl/tern_closure_mux.sv
// Module: top of the ternary closure selector.
// Normalises all inputs, then reduces 2^SEL_W data items through SEL_W
// levels; level l uses select digit l. Purely combinational, SEL_W >= 1.
module tern_closure_mux #(
    parameter int SEL_W   = 3,
    parameter bit CONTAIN = 1'b1
) (
    input  logic [2*(1<<SEL_W)-1:0] data_i,
    input  logic [2*SEL_W-1:0]      sel_i,
    output logic [1:0]              y_o
);
    localparam int ITEMS  = 1 << SEL_W;
    localparam int DATA_W = 2 * ITEMS;
    localparam int SELB_W = 2 * SEL_W;

    logic [DATA_W-1:0] data_c;
    logic [SELB_W-1:0] sel_c;

    tern_normalize #(.N(ITEMS)) i_norm_data (
        .raw_i   (data_i),
        .canon_o (data_c)
    );

    tern_normalize #(.N(SEL_W)) i_norm_sel (
        .raw_i   (sel_i),
        .canon_o (sel_c)
    );

    for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
        localparam int N = ITEMS >> l;
        logic [2*N-1:0] lvl_d;
        logic [N-1:0]   lvl_y;

        // Level input: normalised data first, else previous level output.
        if (l == 0) begin : g_first
            assign lvl_d = data_c;
        end else begin : g_next
            assign lvl_d = g_lvl[l-1].lvl_y;
        end

        tern_mux_level #(.ITEMS(N), .CONTAIN(CONTAIN)) i_level (
            .d_i (lvl_d),
            .s_i (sel_c[2*l+:2]),
            .y_o (lvl_y)
        );
    end

    assign y_o = g_lvl[SEL_W-1].lvl_y;
endmodule

// Checker: port-level properties of the selector, bound to every instance.
module tern_closure_mux_chk #(
    parameter int SEL_W   = 3,
    parameter bit CONTAIN = 1'b1
) (
    input logic [2*(1<<SEL_W)-1:0] data_i,
    input logic [2*SEL_W-1:0]      sel_i,
    input logic [1:0]              y_o
);
    localparam int ITEMS = 1 << SEL_W;

    logic       sel_ok;
    int         idx;
    logic [1:0] picked;
    logic       all_one;
    logic       all_zero;

    // Decode a fully stable select and summarise the data.
    always_comb begin
        sel_ok   = 1'b1;
        idx      = 0;
        all_one  = 1'b1;
        all_zero = 1'b1;
        for (int j = 0; j < SEL_W; j++) begin
            if (sel_i[2*j+:2] == 2'b11) idx = idx | (1 << j);
            else if (sel_i[2*j+:2] != 2'b00) sel_ok = 1'b0;
        end
        for (int i = 0; i < ITEMS; i++) begin
            if (data_i[2*i+:2] != 2'b11) all_one = 1'b0;
            if (data_i[2*i+:2] != 2'b00) all_zero = 1'b0;
        end
        picked = data_i[2*idx+:2];
    end

    // Output checks against the summaries.
    always_comb begin
        // R1
        enc_legal_chk: assert (y_o != 2'b10);
        // R2
        stable_pick_chk: assert (!sel_ok || y_o == {&picked, |picked});
        // R3
        all_zero_chk: assert (!all_zero || y_o == 2'b00);
        if (CONTAIN) begin
            // R3
            all_one_chk: assert (!all_one || y_o == 2'b11);
        end
    end
endmodule

bind tern_closure_mux tern_closure_mux_chk #(.SEL_W(SEL_W), .CONTAIN(CONTAIN)) i_chk (
    .data_i (data_i),
    .sel_i  (sel_i),
    .y_o    (y_o)
);

// File: tb/test_tern_closure_mux.sv
// Bench: directed corners plus seeded random data with every ternary select.
module test_tern_closure_mux;
    localparam int K  = 3;
    localparam int NI = 1 << K;
    localparam int DW = 2 * NI;
    localparam int SW = 2 * K;
    localparam int NSEL = 27; // 3^K

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] data = '0;
    logic [SW-1:0] sel = '0;
    logic [1:0]    y;
    logic [1:0]    y_plain;
    int            nchk = 0;
    int            nerr = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    tern_closure_mux #(.SEL_W(K), .CONTAIN(1'b1)) i_tern_closure_mux (
        .data_i (data), .sel_i (sel), .y_o (y)
    );

    tern_closure_mux #(.SEL_W(K), .CONTAIN(1'b0)) i_tern_closure_mux_plain (
        .data_i (data), .sel_i (sel), .y_o (y_plain)
    );

    // Closure by enumeration of every stable resolution of the select.
    function automatic logic [1:0] ref_closure(logic [DW-1:0] d, logic [SW-1:0] s);
        bit seen0 = 0;
        bit seen1 = 0;
        for (int c = 0; c < NI; c++) begin
            bit ok = 1;
            for (int j = 0; j < K; j++) begin
                if (s[2*j+:2] == 2'b00 && c[j]) ok = 0;
                if (s[2*j+:2] == 2'b11 && !c[j]) ok = 0;
            end
            if (ok) begin
                if (d[2*c+:2] == 2'b00) seen0 = 1;
                else if (d[2*c+:2] == 2'b11) seen1 = 1;
                else begin seen0 = 1; seen1 = 1; end
            end
        end
        if (seen0 && seen1) return 2'b01;
        return seen1 ? 2'b11 : 2'b00;
    endfunction

    // Ternary select number t (base 3, digit 0 lowest): 0->00, 1->11, 2->01.
    function automatic logic [SW-1:0] sel_of(int t);
        logic [SW-1:0] s = '0;
        int v = t;
        for (int j = 0; j < K; j++) begin
            case (v % 3)
                0: s[2*j+:2] = 2'b00;
                1: s[2*j+:2] = 2'b11;
                default: s[2*j+:2] = 2'b01;
            endcase
            v = v / 3;
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] table_of(int kind);
        logic [DW-1:0] d = '0;
        for (int i = 0; i < NI; i++) begin
            bit f = (kind == 0) ? ((i[0] + i[1] + i[2]) >= 2) : ^i[2:0];
            d[2*i+:2] = f ? 2'b11 : 2'b00;
        end
        return d;
    endfunction

    task automatic apply(logic [DW-1:0] d, logic [SW-1:0] s);
        @(posedge clk);
        data = d;
        sel  = s;
        @(negedge clk);
    endtask

    task automatic check(logic [1:0] got, logic [1:0] exp, string req);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %b expected %b (data=%h sel=%b)", req, got, exp, data, sel);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog (all R): got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(y, 2'b00, "R1 reset all-zero inputs");
        rst_n = 1'b1;

        // R2: stable selects over a distinct pattern.
        d = '0;
        for (int i = 0; i < NI; i++) d[2*i+:2] = (i % 3 == 1) ? 2'b11 : 2'b00;
        for (int t = 0; t < NI; t++) begin
            logic [SW-1:0] s = '0;
            for (int j = 0; j < K; j++) s[2*j+:2] = t[j] ? 2'b11 : 2'b00;
            apply(d, s);
            check(y, (t % 3 == 1) ? 2'b11 : 2'b00, "R2 stable select");
            check(y_plain, (t % 3 == 1) ? 2'b11 : 2'b00, "R8 plain stable select");
        end

        // R5: digit 0 M, digit 1 = 1, digit 2 = 0 -> candidates 2 and 3.
        d = '0; d[5:4] = 2'b11; d[7:6] = 2'b11;
        apply(d, {2'b00, 2'b11, 2'b01});
        check(y, 2'b11, "R5 agreeing ones");
        check(y_plain, 2'b01, "R8 plain agreeing ones gives M");
        d = '1; d[5:4] = 2'b00; d[7:6] = 2'b00;
        apply(d, {2'b00, 2'b11, 2'b01});
        check(y, 2'b00, "R5 agreeing zeros");
        d = '0; d[5:4] = 2'b11;
        apply(d, {2'b00, 2'b11, 2'b01});
        check(y, 2'b01, "R5 differing candidates");

        // R3: uniform data, all select digits M.
        apply('1, {K{2'b01}});
        check(y, 2'b11, "R3 all ones");
        check(y_plain, 2'b01, "R8 plain all ones gives M");
        apply('0, {K{2'b01}});
        check(y, 2'b00, "R3 all zeros");

        // R6: M on unreachable item ignored, on reachable item propagated.
        d = '0; d[2*7+:2] = 2'b01;
        apply(d, {K{2'b00}});
        check(y, 2'b00, "R6 unreachable M ignored");
        apply(d, {2'b11, 2'b11, 2'b01});
        check(y, 2'b01, "R6 reachable M");

        // R9: code 10 behaves as M on data and select.
        d = '0; d[2*3+:2] = 2'b10;
        apply(d, {2'b00, 2'b11, 2'b11});
        check(y, 2'b01, "R9 data 10 as M");
        d = '0; d[5:4] = 2'b11; d[7:6] = 2'b11;
        apply(d, {2'b00, 2'b11, 2'b10});
        check(y, 2'b11, "R9 select 10 as M agreeing");
        d = '0; d[5:4] = 2'b11;
        apply(d, {2'b00, 2'b11, 2'b10});
        check(y, 2'b01, "R9 select 10 as M differing");

        // R7: majority and parity truth tables over every ternary select.
        for (int k = 0; k < 2; k++) begin
            for (int t = 0; t < NSEL; t++) begin
                apply(table_of(k), sel_of(t));
                check(y, ref_closure(table_of(k), sel_of(t)), "R7 truth-table closure");
            end
        end

        // R4 and R1: seeded random data, every ternary select.
        for (int v = 0; v < 40; v++) begin
            d = '0;
            for (int i = 0; i < NI; i++) begin
                int r = $urandom % 8;
                d[2*i+:2] = (r < 3) ? 2'b00 : (r < 6) ? 2'b11 : (r == 6) ? 2'b01 : 2'b10;
            end
            for (int t = 0; t < NSEL; t++) begin
                apply(d, sel_of(t));
                check(y, ref_closure(d, sel_of(t)), "R4 random closure");
            end
            check((y == 2'b10) ? 2'b10 : 2'b00, 2'b00, "R1 output code legal");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule